// File: doc/BRIEF.md
# Per-Access-Type Direct-Mapped Translation Buffer

This block turns a virtual address into a physical address for 4 KiB pages. It holds one shared array of physical frame numbers and three separate tag arrays: one answers instruction fetches, one answers stores and one answers loads. Each array is direct-mapped and indexed by the virtual page number. Access rights are never stored as bits in an entry. A kind of access is allowed only when the tag array for that kind holds a valid, matching tag. An entry installed with read rights only therefore hits for loads and misses for stores and fetches.

A lookup is presented with a virtual address and two flags, fetch and store. One cycle later the block reports either a hit with the physical address or a miss. A miss carries the address and the access kind toward an external page-table walker, which is not part of this block. The walker answers through the refill port with a virtual page number, a frame number and a six-bit rights field. The block combines that field with the current privilege level to decide which tag arrays receive the tag. Writing the page-table base register page-aligns the written value and invalidates every entry in all three arrays in a single cycle.

Top module: `pt_tlb_top`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid` and `miss_req` are 0, `ptb_q` is 0, and every lookup misses until a refill installs an entry.
- R2: The index is vaddr[19:12] (256 entries). A hit requires a valid entry at that index whose stored tag equals vaddr[31:20] in the tag array selected for the access kind.
- R3: The array is chosen by priority. If `lk_fetch` is 1 the fetch array is used, even when `lk_store` is also 1. Otherwise, if `lk_store` is 1 the store array is used. Otherwise the load array is used.
- R4: On a hit, `rsp_paddr` equals the stored 20-bit frame number in bits 31:12, with vaddr[11:0] in bits 11:0.
- R5: On a miss, `miss_req` is 1 and `rsp_hit` is 0. `miss_vaddr` equals the looked-up address. `miss_fetch` is 1 for a fetch. `miss_store` is 1 for a store that is not a fetch. Exactly one of `rsp_hit` and `miss_req` is 1 whenever `rsp_valid` is 1.
- R6: A refill writes the frame number at index rf_vpn[7:0]. It writes tag rf_vpn[19:8] into each array whose right is granted and invalidates that index in the other arrays. The rights field `rf_perm` is laid out as follows:
  - In supervisor mode (`priv_super`=1), bit 5 grants load, bit 4 grants store and bit 3 grants fetch.
  - In user mode, bit 2 grants load, bit 1 grants store and bit 0 grants fetch.
- R7: A base write loads `ptb_q` with `ptb_wdata` with bits 11:0 cleared, visible on the cycle after the write.
- R8: A base write invalidates every entry in all three arrays. When it coincides with a refill, the invalidation wins and the refilled entry is not valid afterwards.
- R9: A lookup in the same cycle as a refill or base write sees the contents from before that update.
- R10: Responses are registered. `rsp_valid` is 1 exactly on the cycle after a cycle with `lk_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_fetch | input | 1 | Lookup is an instruction fetch |
| lk_store | input | 1 | Lookup is a store |
| rf_valid | input | 1 | Refill write |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_ppn | input | 20 | Refill physical frame number |
| rf_perm | input | 6 | Refill rights: S load/store/fetch in 5:3, U load/store/fetch in 2:0 |
| priv_super | input | 1 | Current privilege is supervisor |
| ptb_we | input | 1 | Page-table base write and flush |
| ptb_wdata | input | 32 | Page-table base write value |
| ptb_q | output | 32 | Page-aligned page-table base |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 32 | Physical address on hit |
| miss_req | output | 1 | Miss raised toward the walker |
| miss_vaddr | output | 32 | Missing virtual address |
| miss_fetch | output | 1 | Miss was a fetch |
| miss_store | output | 1 | Miss was a store (not fetch) |

## Verification
The bench targets the following corner cases:

- **Array priority.** A lookup with both flags set must use the fetch array. A design that gives store priority would hit on an entry that has only store rights.
- **Privilege split.** Refills are issued in both privilege levels with rights fields where the supervisor and user triplets disagree. A design that swaps the triplets grants user code rights it lacks.
- **Aliasing.** Addresses that share an index but differ in tag must replace each other. A refill must invalidate the arrays it does not grant, or a stale tag from the earlier page would still hit.
- **Flush against refill.** Same-cycle refill and base write must leave the entry invalid, and a same-cycle lookup must see the old contents. A design with the wrong precedence would return hits right after a flush.

// File: rtl/pt_tlb_pkg.sv
// Package: shared constants and the access-kind encoding for the translation buffer.
// Assumes 4 KiB pages; the access kind doubles as the tag-array number.
package pt_tlb_pkg;
    localparam int PAGE_SHIFT = 12;
    localparam int NUM_KINDS  = 3;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_FETCH = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/pt_tlb_rights.sv
// Rights decoder: turns the six-bit rights field plus privilege level into
// one grant bit per tag array. Assumes the supervisor triplet is in bits 5:3
// and the user triplet in bits 2:0, each ordered load, store, fetch.
module pt_tlb_rights
    import pt_tlb_pkg::*;
(
    input  logic [5:0]           perm,
    input  logic                 is_super,
    output logic [NUM_KINDS-1:0] grant
);
    // Pick the triplet for the current privilege level and spread it by kind.
    always_comb begin
        grant             = '0;
        grant[KIND_LOAD]  = is_super ? perm[5] : perm[2];
        grant[KIND_STORE] = is_super ? perm[4] : perm[1];
        grant[KIND_FETCH] = is_super ? perm[3] : perm[0];
    end
endmodule

// File: rtl/pt_tlb_tag_bank.sv
// Tag bank: one direct-mapped tag array with a valid bit per entry.
// Assumes at most one write per cycle; flush clears all valid bits in one
// cycle and takes precedence over a write. Reads are combinational.
module pt_tlb_tag_bank #(
    parameter int ENTRIES = 256,
    parameter int TAG_W   = 12,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic             wr_keep,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];

    // Valid bits: reset and flush clear all; a write sets or clears one.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_keep;
        end
    end

    // Tag storage: only written when this kind of access is granted.
    always_ff @(posedge clk) begin
        if (wr_en && wr_keep) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    // Compare the addressed entry against the expected tag.
    assign rd_hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
endmodule

// File: rtl/pt_tlb_frames.sv
// Frame store: physical frame number per index, shared by all access kinds.
// Assumes validity is tracked by the tag banks, so no reset is needed here.
module pt_tlb_frames #(
    parameter int ENTRIES = 256,
    parameter int FRM_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [FRM_W-1:0] wr_frame,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [FRM_W-1:0] rd_frame
);
    logic [FRM_W-1:0] frame_q [ENTRIES];

    // Frame write on every refill, whatever rights it carries.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            frame_q[wr_idx] <= wr_frame;
        end
    end

    assign rd_frame = frame_q[rd_idx];
endmodule

// File: rtl/pt_tlb_top.sv
// Top: direct-mapped translation buffer with one tag array per access kind.
// Lookup results are registered (one-cycle latency). Same-cycle lookups see
// the state before any refill or flush in that cycle. Assumes 4 KiB pages.
module pt_tlb_top
    import pt_tlb_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int VPN_W  = VA_W - PAGE_SHIFT,
    localparam int TAG_W  = VPN_W - IDX_W,
    localparam int FRM_W  = PA_W - PAGE_SHIFT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic [VA_W-1:0] lk_vaddr,
    input  logic            lk_fetch,
    input  logic            lk_store,
    input  logic            rf_valid,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [FRM_W-1:0] rf_ppn,
    input  logic [5:0]      rf_perm,
    input  logic            priv_super,
    input  logic            ptb_we,
    input  logic [PA_W-1:0] ptb_wdata,
    output logic [PA_W-1:0] ptb_q,
    output logic            rsp_valid,
    output logic            rsp_hit,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            miss_req,
    output logic [VA_W-1:0] miss_vaddr,
    output logic            miss_fetch,
    output logic            miss_store
);
    localparam logic [PA_W-1:0] PAGE_MASK = PA_W'((1 << PAGE_SHIFT) - 1);

    logic [IDX_W-1:0]     lk_idx;
    logic [TAG_W-1:0]     lk_tag;
    logic [IDX_W-1:0]     rf_idx;
    logic [TAG_W-1:0]     rf_tag;
    logic [NUM_KINDS-1:0] grant;
    logic [NUM_KINDS-1:0] bank_hit;
    logic [FRM_W-1:0]     lk_frame;
    acc_kind_e            lk_kind;
    logic                 sel_hit;

    assign lk_idx = lk_vaddr[PAGE_SHIFT +: IDX_W];
    assign lk_tag = lk_vaddr[VA_W-1 -: TAG_W];
    assign rf_idx = rf_vpn[IDX_W-1:0];
    assign rf_tag = rf_vpn[VPN_W-1 -: TAG_W];

    // Choose which tag array answers: fetch first, then store, then load.
    always_comb begin
        if (lk_fetch)      lk_kind = KIND_FETCH;
        else if (lk_store) lk_kind = KIND_STORE;
        else               lk_kind = KIND_LOAD;
    end

    pt_tlb_rights u_rights (
        .perm     (rf_perm),
        .is_super (priv_super),
        .grant    (grant)
    );

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_bank
        pt_tlb_tag_bank #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (ptb_we),
            .wr_en   (rf_valid),
            .wr_keep (grant[k]),
            .wr_idx  (rf_idx),
            .wr_tag  (rf_tag),
            .rd_idx  (lk_idx),
            .rd_tag  (lk_tag),
            .rd_hit  (bank_hit[k])
        );
    end

    pt_tlb_frames #(.ENTRIES(ENTRIES), .FRM_W(FRM_W)) u_frames (
        .clk      (clk),
        .wr_en    (rf_valid),
        .wr_idx   (rf_idx),
        .wr_frame (rf_ppn),
        .rd_idx   (lk_idx),
        .rd_frame (lk_frame)
    );

    assign sel_hit = bank_hit[lk_kind];

    // Page-table base register: stored page-aligned.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptb_q <= '0;
        else if (ptb_we) ptb_q <= ptb_wdata & ~PAGE_MASK;
    end

    // Response flags: one cycle after each lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            miss_req  <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && sel_hit;
            miss_req  <= lk_valid && !sel_hit;
        end
    end

    // Response payload: translated address and miss details.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_paddr  <= '0;
            miss_vaddr <= '0;
            miss_fetch <= 1'b0;
            miss_store <= 1'b0;
        end else if (lk_valid) begin
            rsp_paddr  <= {lk_frame, lk_vaddr[PAGE_SHIFT-1:0]};
            miss_vaddr <= lk_vaddr;
            miss_fetch <= (lk_kind == KIND_FETCH);
            miss_store <= (lk_kind == KIND_STORE);
        end
    end
endmodule

// File: rtl/pt_tlb_checker.sv
// Checker: protocol properties of the translation buffer, bound to the top.
module pt_tlb_checker #(
    parameter int VA_W = 32,
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            ptb_we,
    input logic [PA_W-1:0] ptb_q,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            miss_req,
    input logic [VA_W-1:0] miss_vaddr
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> rsp_valid); // R10
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |=> !rsp_valid); // R10
    AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> (rsp_hit != miss_req)); // R5
    AST_MISS_ADDR: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> (!miss_req || miss_vaddr == $past(lk_vaddr))); // R5
    AST_PADDR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> (!rsp_hit || rsp_paddr[11:0] == $past(lk_vaddr[11:0]))); // R4
    AST_PTB_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) ptb_we |=> (ptb_q[11:0] == 12'd0)); // R7
    AST_FLUSH_MISSES: assert property (@(posedge clk) disable iff (!rst_n) (lk_valid && $past(ptb_we)) |=> !rsp_hit); // R8
endmodule

bind pt_tlb_top pt_tlb_checker #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/tb_pt_tlb_top.sv
`timescale 1ns/1ps
module tb_pt_tlb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_fetch = 0, lk_store = 0;
    logic [31:0] lk_vaddr = '0;
    logic        rf_valid = 0, priv_super = 0, ptb_we = 0;
    logic [19:0] rf_vpn = '0, rf_ppn = '0;
    logic [5:0]  rf_perm = '0;
    logic [31:0] ptb_wdata = '0;
    logic [31:0] ptb_q, rsp_paddr, miss_vaddr;
    logic        rsp_valid, rsp_hit, miss_req, miss_fetch, miss_store;

    int checks = 0, fails = 0;
    bit done = 0;

    // Reference model: valid/tag per kind (0 load, 1 store, 2 fetch) and frames.
    bit          m_v [3][256];
    logic [11:0] m_t [3][256];
    logic [19:0] m_f [256];

    always #2.5 clk = ~clk;

    pt_tlb_top dut (.*);

    function automatic int kind_of(input bit f, input bit s);
        return f ? 2 : (s ? 1 : 0);
    endfunction

    function automatic bit granted(input logic [5:0] p, input bit sup, input int k);
        return sup ? p[5-k] : p[2-k];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model update at posedge, check at next negedge.
    task automatic step(input bit lk, input logic [31:0] va, input bit f, input bit s,
                        input bit rf, input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic [5:0] perm, input bit sup,
                        input bit pw, input logic [31:0] pd);
        int k, ix;
        bit e_hit;
        logic [31:0] e_pa;
        lk_valid = lk; lk_vaddr = va; lk_fetch = f; lk_store = s;
        rf_valid = rf; rf_vpn = vpn; rf_ppn = ppn; rf_perm = perm; priv_super = sup;
        ptb_we = pw; ptb_wdata = pd;
        @(posedge clk);
        k = kind_of(f, s);
        ix = int'(va[19:12]);
        e_hit = m_v[k][ix] && m_t[k][ix] == va[31:20];
        e_pa = {m_f[ix], va[11:0]};
        if (rf) begin
            for (int j = 0; j < 3; j++) begin
                m_v[j][vpn[7:0]] = granted(perm, sup, j);
                if (granted(perm, sup, j)) m_t[j][vpn[7:0]] = vpn[19:8];
            end
            m_f[vpn[7:0]] = ppn;
        end
        if (pw) for (int j = 0; j < 3; j++) for (int i = 0; i < 256; i++) m_v[j][i] = 0;
        @(negedge clk);
        check(rsp_valid == lk, "R10 rsp_valid", {31'd0, rsp_valid}, {31'd0, lk});
        if (lk) begin
            check(rsp_hit == e_hit, "R2/R3 hit", {31'd0, rsp_hit}, {31'd0, e_hit});
            if (e_hit) check(rsp_paddr == e_pa, "R4 paddr", rsp_paddr, e_pa);
            else begin
                check(miss_req && miss_vaddr == va, "R5 miss addr", miss_vaddr, va);
                check(miss_fetch == (k == 2) && miss_store == (k == 1), "R5 miss kind",
                      {30'd0, miss_fetch, miss_store}, {30'd0, k == 2, k == 1});
            end
        end
        if (pw) check(ptb_q == {pd[31:12], 12'd0}, "R7 base align", ptb_q, {pd[31:12], 12'd0});
        lk_valid = 0; rf_valid = 0; ptb_we = 0;
    endtask

    task automatic look(input logic [31:0] va, input bit f, input bit s);
        step(1, va, f, s, 0, '0, '0, '0, 0, 0, '0);
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [5:0] perm, input bit sup);
        step(0, '0, 0, 0, 1, vpn, ppn, perm, sup, 0, '0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit f, s;
        logic [31:0] va;
        int r;
        logic [19:0] vpn;
        void'($urandom(32'h5EED_0042));
        for (int j = 0; j < 3; j++) for (int i = 0; i < 256; i++) m_v[j][i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check(rsp_valid == 0 && miss_req == 0, "R1 idle outputs", {30'd0, rsp_valid, miss_req}, 32'd0);
        check(ptb_q == 0, "R1 base reset", ptb_q, 32'd0);
        look(32'h0000_3123, 0, 0);  // R1 empty buffer misses
        look(32'h0000_3123, 1, 0);
        // R6 supervisor load+store only; R2 tag match, R4 paddr
        fill(20'h00103, 20'hABCDE, 6'b110_001, 1);
        look(32'h0010_3456, 0, 0);
        look(32'h0010_3456, 0, 1);
        look(32'h0010_3456, 1, 0);  // fetch: not granted in supervisor
        look(32'h0010_3456, 1, 1);  // R3 fetch wins over store -> miss
        // R6 user mode uses low triplet: fetch only
        fill(20'h00103, 20'h12345, 6'b110_001, 0);
        look(32'h0010_3FFF, 1, 1);  // R3 hit via fetch array
        look(32'h0010_3000, 0, 0);  // load invalidated
        // R2 alias: same index, different tag
        look(32'h0020_3000, 1, 0);
        // R9/R8: refill + flush + lookup same cycle
        step(1, 32'h0010_3000, 1, 0, 1, 20'h00103, 20'h55555, 6'b111_111, 1, 1, 32'hDEAD_BEEF);
        look(32'h0010_3000, 1, 0);  // R8 flush wins
        // R9 lookup same cycle as refill sees old content
        step(1, 32'h0040_5010, 0, 0, 1, 20'h00405, 20'h0F0F0, 6'b100_000, 1, 0, '0);
        look(32'h0040_5010, 0, 0);
        // constrained random
        for (int n = 0; n < 4000; n++) begin
            r = int'($urandom_range(0, 99));
            f = ($urandom_range(0, 2) == 0);
            s = $urandom_range(0, 1) == 1;
            va = {12'(($urandom_range(0, 2) == 0) ? 12'h001 : ($urandom_range(0, 1) ? 12'h7FF : 12'hABC)),
                  8'(($urandom_range(0, 1) == 1) ? 8'hFF : 8'(3 + $urandom_range(0, 2))),
                  12'($urandom)};
            vpn = {va[31:20] ^ 12'(($urandom_range(0, 3) == 0) ? 12'h7FE : 12'h000), va[19:12]};
            step(r < 60, va, f, s, (r > 40 && r < 95), vpn, 20'($urandom), 6'($urandom),
                 $urandom_range(0, 1) == 1, r >= 98, $urandom);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule